// File: doc/BRIEF.md
# Float-to-Integer Converter

This block turns a 32-bit single-precision floating-point operand into a 32-bit two's-complement integer. A host raises `start` for one cycle with an operation code and the operand. The code selects one of two modes: truncation toward zero, or rounding to the nearest integer with exact halves moving away from zero.

The conversion logic between the input and the output register is purely combinational. The block takes the operand apart, shifts the significand into place according to the exponent, applies the selected rounding, then saturates or negates as needed. `done` and `result` are registered, so the converted value appears on the clock edge after the accepted `start`. Subnormal operands are treated as zero. Out-of-range values and infinities are clamped to the two extreme integer codes, and a NaN always yields the largest positive code, so the output is always fully defined.

Top module: `f2i_convert`

## Requirements
- R1: While `rst_n` is low, `done` is 0 and `result` is 0.
- R2: A `start` with `op_code` 249 or 248 is accepted. `done` is then 1 in the next clock cycle only, and `result` holds the converted value from that cycle until the next accepted start. A `start` with any other code is ignored: `done` stays 0 and `result` keeps its value.
- R3: The operand layout is sign in bit 31, biased exponent in bits 30:23 (bias 127) and fraction in bits 22:0. Code 249 truncates toward zero: 4.8 gives 4 and -1.5 gives -1.
- R4: Code 248 rounds to the nearest integer, and an exact half moves away from zero: 4.8 gives 5, -1.5 gives -2, 2.5 gives 3 and -0.5 gives -1.
- R5: A biased exponent from 1 to 125 (magnitude under 0.5) gives 0 in both modes. A magnitude from 0.5 up to but not including 1 gives 0 under code 249, and 1 or -1 (following the sign) under code 248.
- R6: A biased exponent of 0 (zero or subnormal, either sign) gives 0 in both modes.
- R7: A positive value of 2^31 or more, and plus infinity (exponent 255, fraction 0), give 0x7FFFFFFF. A NaN (exponent 255, fraction nonzero) of either sign also gives 0x7FFFFFFF.
- R8: A value of -2^31 or below, and minus infinity, give 0x80000000. An operand of exactly -2^31 gives 0x80000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a conversion this cycle |
| op_code | input | 8 | 249 selects truncation, 248 selects nearest with ties away |
| operand | input | 32 | Single-precision operand |
| done | output | 1 | One-cycle pulse, `result` is valid |
| result | output | 32 | Two's-complement integer result |

## Verification
The assertions assume that `op_code` and `operand` carry defined values whenever `start` is high, and that they only matter in the cycle where `start` is sampled. Nothing is assumed about back-to-back requests, because every accepted start simply reloads the output register. The stimulus changes inputs only on falling edges and lowers `start` after each request. It sweeps every biased exponent with several fraction patterns, both signs and both codes, and adds rejected codes and directed tie and boundary values.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

   typedef enum logic {
      RND_TRUNC = 1'b0,
      RND_AWAY  = 1'b1
   } rnd_mode_e;

   typedef struct packed {
      logic sign;
      logic is_zero;
      logic is_inf;
      logic is_nan;
   } fclass_t;

endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
   import f2i_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   localparam int FLT_W = 1 + EXP_W + MAN_W
) (
   input  logic [FLT_W-1:0] operand_i,
   output fclass_t          cls_o,
   output logic [EXP_W-1:0] exp_o,
   output logic [MAN_W:0]   mant_o
);

   logic [EXP_W-1:0] exp_f;
   logic [MAN_W-1:0] frac_f;
   logic             exp_lo;
   logic             exp_hi;

   assign exp_f  = operand_i[FLT_W-2:MAN_W];
   assign frac_f = operand_i[MAN_W-1:0];
   assign exp_lo = (exp_f == '0);
   assign exp_hi = &exp_f;

   // subnormals are flushed: a zero exponent is classed as zero
   assign cls_o.sign    = operand_i[FLT_W-1];
   assign cls_o.is_zero = exp_lo;
   assign cls_o.is_inf  = exp_hi & ~(|frac_f);
   assign cls_o.is_nan  = exp_hi & (|frac_f);

   assign exp_o  = exp_f;
   assign mant_o = {~exp_lo, frac_f};

endmodule

// File: rtl/f2i_align.sv
module f2i_align #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   parameter int INT_W = 32,
   localparam int BIAS = (1 << (EXP_W - 1)) - 1,
   localparam int SHW  = INT_W + MAN_W + 1,
   localparam int SAW  = $clog2(INT_W + 1)
) (
   input  logic [EXP_W-1:0] exp_i,
   input  logic [MAN_W:0]   mant_i,
   output logic [INT_W-1:0] int_mag_o,
   output logic             half_o,
   output logic             too_big_o
);

   localparam logic signed [EXP_W+1:0] K_BIAS = (EXP_W + 2)'(BIAS);
   localparam logic signed [EXP_W+1:0] K_SAT  = (EXP_W + 2)'(INT_W - 1);
   localparam logic signed [EXP_W+1:0] K_MIN  = -(EXP_W + 2)'(1);

   if (SAW > EXP_W + 2) begin : g_bad_shift_width
      $error("f2i_align: shift amount wider than exponent path");
   end
   if (INT_W - 1 > BIAS) begin : g_bad_int_width
      $error("f2i_align: integer width exceeds exponent range");
   end

   logic signed [EXP_W+1:0] k_unb;
   logic signed [EXP_W+1:0] k_plus1;
   logic [SAW-1:0]          shamt;
   logic [SHW-1:0]          ext;
   logic [SHW-1:0]          sh;
   logic                    tiny;
   logic                    unused_bits;

   assign k_unb   = $signed({2'b00, exp_i}) - K_BIAS;
   assign k_plus1 = k_unb + (EXP_W + 2)'(1);
   assign tiny    = (k_unb < K_MIN);
   assign too_big_o = (k_unb >= K_SAT);

   // sh = value * 2^(MAN_W+1): integer part on top, half bit just below
   assign shamt = (tiny || too_big_o) ? '0 : k_plus1[SAW-1:0];
   assign ext   = {{(SHW - MAN_W - 1){1'b0}}, mant_i};
   assign sh    = ext << shamt;

   assign int_mag_o = tiny ? '0 : sh[SHW-1 -: INT_W];
   assign half_o    = tiny ? 1'b0 : sh[MAN_W];

   assign unused_bits = ^{sh[MAN_W-1:0], k_plus1[EXP_W+1:SAW]};

endmodule

// File: rtl/f2i_round_sat.sv
module f2i_round_sat
   import f2i_pkg::*;
#(
   parameter int INT_W = 32
) (
   input  fclass_t          cls_i,
   input  rnd_mode_e        mode_i,
   input  logic [INT_W-1:0] int_mag_i,
   input  logic             half_i,
   input  logic             too_big_i,
   output logic [INT_W-1:0] result_o
);

   localparam logic [INT_W-1:0] POS_MAX = {1'b0, {(INT_W - 1){1'b1}}};
   localparam logic [INT_W-1:0] NEG_MIN = {1'b1, {(INT_W - 1){1'b0}}};
   localparam logic [INT_W:0]   POS_LIM = {2'b00, {(INT_W - 1){1'b1}}};
   localparam logic [INT_W:0]   NEG_LIM = {2'b01, {(INT_W - 1){1'b0}}};

   logic             rnd_up;
   logic [INT_W:0]   sum;
   logic [INT_W-1:0] clamp;

   assign rnd_up = (mode_i == RND_AWAY) && half_i;
   assign sum    = {1'b0, int_mag_i} + {{INT_W{1'b0}}, rnd_up};
   assign clamp  = cls_i.sign ? NEG_MIN : POS_MAX;

   always_comb begin
      if (cls_i.is_nan)                       result_o = POS_MAX;
      else if (cls_i.is_inf || too_big_i)     result_o = clamp;
      else if (cls_i.is_zero)                 result_o = '0;
      else if (!cls_i.sign && sum > POS_LIM)  result_o = POS_MAX;
      else if (cls_i.sign && sum > NEG_LIM)   result_o = NEG_MIN;
      else if (cls_i.sign)                    result_o = -sum[INT_W-1:0];
      else                                    result_o = sum[INT_W-1:0];
   end

   always_comb begin
      if (!cls_i.is_nan && !cls_i.is_zero && !cls_i.sign)
         assert_pos_not_negative_R3: assert (!result_o[INT_W-1]);
   end

endmodule

// File: rtl/f2i_convert.sv
module f2i_convert
   import f2i_pkg::*;
#(
   parameter int EXP_W     = 8,
   parameter int MAN_W     = 23,
   parameter int INT_W     = 32,
   parameter int OPC_W     = 8,
   parameter int OPC_TRUNC = 249,
   parameter int OPC_ROUND = 248,
   localparam int FLT_W    = 1 + EXP_W + MAN_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [OPC_W-1:0] op_code,
   input  logic [FLT_W-1:0] operand,
   output logic             done,
   output logic [INT_W-1:0] result
);

   localparam logic [OPC_W-1:0] CODE_TRUNC = OPC_W'(OPC_TRUNC);
   localparam logic [OPC_W-1:0] CODE_ROUND = OPC_W'(OPC_ROUND);
   localparam logic [INT_W-1:0] POS_MAX    = {1'b0, {(INT_W - 1){1'b1}}};
   localparam logic [INT_W-1:0] NEG_MIN    = {1'b1, {(INT_W - 1){1'b0}}};
   localparam logic [EXP_W-1:0] EXP_HALF   = EXP_W'((1 << (EXP_W - 1)) - 2);

   if (OPC_TRUNC == OPC_ROUND) begin : g_bad_codes
      $error("f2i_convert: the two operation codes must differ");
   end
   if (OPC_TRUNC >= (1 << OPC_W) || OPC_ROUND >= (1 << OPC_W)) begin : g_bad_code_width
      $error("f2i_convert: operation code does not fit OPC_W");
   end

   fclass_t          cls;
   rnd_mode_e        mode;
   logic [EXP_W-1:0] exp_v;
   logic [MAN_W:0]   mant_v;
   logic [INT_W-1:0] int_mag;
   logic             half_bit;
   logic             too_big;
   logic [INT_W-1:0] conv;
   logic             op_ok;

   assign op_ok = (op_code == CODE_TRUNC) || (op_code == CODE_ROUND);
   assign mode  = (op_code == CODE_TRUNC) ? RND_TRUNC : RND_AWAY;

   f2i_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack (
      .operand_i (operand),
      .cls_o     (cls),
      .exp_o     (exp_v),
      .mant_o    (mant_v)
   );

   f2i_align #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_align (
      .exp_i     (exp_v),
      .mant_i    (mant_v),
      .int_mag_o (int_mag),
      .half_o    (half_bit),
      .too_big_o (too_big)
   );

   f2i_round_sat #(.INT_W(INT_W)) u_round_sat (
      .cls_i     (cls),
      .mode_i    (mode),
      .int_mag_i (int_mag),
      .half_i    (half_bit),
      .too_big_i (too_big),
      .result_o  (conv)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done   <= 1'b0;
         result <= '0;
      end else begin
         done <= start && op_ok;
         if (start && op_ok) result <= conv;
      end
   end

   assert_done_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op_ok) |=> done);

   assert_bad_code_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !op_ok) |=> (!done && $stable(result)));

   assert_small_is_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op_ok && operand[FLT_W-2:MAN_W] < EXP_HALF) |=> (result == '0));

   assert_pos_inf_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op_ok && operand == {1'b0, {EXP_W{1'b1}}, {MAN_W{1'b0}}})
      |=> (result == POS_MAX));

   assert_neg_inf_clamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op_ok && operand == {1'b1, {EXP_W{1'b1}}, {MAN_W{1'b0}}})
      |=> (result == NEG_MIN));

endmodule

// File: tb/f2i_convert_test.sv
module f2i_convert_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  op_code = '0;
   logic [31:0] operand = '0;
   logic        done;
   logic [31:0] result;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   f2i_convert uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .op_code (op_code),
      .operand (operand),
      .done    (done),
      .result  (result)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, got, exp);
      end
   endtask

   task automatic convert(input logic [7:0] op, input logic [31:0] x, output logic [31:0] r);
      @(negedge clk);
      start = 1'b1;
      op_code = op;
      operand = x;
      @(negedge clk);
      start = 1'b0;
      check("R2 done pulse", {31'd0, done}, 32'd1);
      r = result;
   endtask

   function automatic logic [31:0] model(input logic [31:0] x, input bit away, output string tag);
      int         e;
      int         f;
      bit         s;
      real        v;
      real        fr;
      longint     t;
      e = int'(x[30:23]);
      f = int'(x[22:0]);
      s = x[31];
      tag = away ? "R4" : "R3";
      if (e == 255) begin
         tag = (f != 0 || !s) ? "R7" : "R8";
         if (f != 0) return 32'h7FFF_FFFF;
         return s ? 32'h8000_0000 : 32'h7FFF_FFFF;
      end
      if (e == 0) begin
         tag = "R6";
         return 32'd0;
      end
      v = (1.0 + real'(f) / 8388608.0) * (2.0 ** (e - 127));
      if (v >= 2147483648.0) begin
         tag = s ? "R8" : "R7";
         return s ? 32'h8000_0000 : 32'h7FFF_FFFF;
      end
      if (v < 1.0) tag = "R5";
      t = longint'($rtoi(v));
      fr = v - real'(t);
      if (away && fr >= 0.5) t = t + 1;
      if (s) t = -t;
      return t[31:0];
   endfunction

   task automatic run_case(input logic [7:0] op, input logic [31:0] x);
      logic [31:0] r;
      logic [31:0] exp;
      string       tag;
      exp = model(x, (op == 8'd248), tag);
      convert(op, x, r);
      check(tag, r, exp);
   endtask

   task automatic directed(input string tag, input logic [7:0] op, input logic [31:0] x,
                           input logic [31:0] exp);
      logic [31:0] r;
      convert(op, x, r);
      check(tag, r, exp);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : stimulus
      logic [31:0] r;
      logic [31:0] frac_set [5];
      frac_set[0] = 32'h0;
      frac_set[1] = 32'h1;
      frac_set[2] = 32'h40_0000;
      frac_set[3] = 32'h7F_FFFF;
      frac_set[4] = 32'h19_999A;

      repeat (3) @(negedge clk);
      // R1 reset values
      check("R1 done in reset", {31'd0, done}, 32'd0);
      check("R1 result in reset", result, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 done after reset", {31'd0, done}, 32'd0);

      // R3 truncation
      directed("R3 4.8 trunc", 8'd249, 32'h4099_999A, 32'd4);
      directed("R3 -1.5 trunc", 8'd249, 32'hBFC0_0000, 32'hFFFF_FFFF);
      // R4 nearest, ties away
      directed("R4 4.8 round", 8'd248, 32'h4099_999A, 32'd5);
      directed("R4 -1.5 round", 8'd248, 32'hBFC0_0000, 32'hFFFF_FFFE);
      directed("R4 2.5 round", 8'd248, 32'h4020_0000, 32'd3);
      directed("R4 -0.5 round", 8'd248, 32'hBF00_0000, 32'hFFFF_FFFF);
      // R5 small magnitudes
      directed("R5 0.75 trunc", 8'd249, 32'h3F40_0000, 32'd0);
      directed("R5 0.75 round", 8'd248, 32'h3F40_0000, 32'd1);
      directed("R5 -0.25 round", 8'd248, 32'hBE80_0000, 32'd0);
      directed("R5 -0.5 trunc", 8'd249, 32'hBF00_0000, 32'd0);
      // R6 zero and subnormal
      directed("R6 subnormal", 8'd248, 32'h0000_0001, 32'd0);
      directed("R6 neg subnormal", 8'd249, 32'h807F_FFFF, 32'd0);
      directed("R6 minus zero", 8'd248, 32'h8000_0000, 32'd0);
      // R7 positive clamp and NaN
      directed("R7 2^31", 8'd249, 32'h4F00_0000, 32'h7FFF_FFFF);
      directed("R7 largest below 2^31", 8'd248, 32'h4EFF_FFFF, 32'h7FFF_FF80);
      directed("R7 plus inf", 8'd248, 32'h7F80_0000, 32'h7FFF_FFFF);
      directed("R7 neg NaN", 8'd249, 32'hFFC0_0000, 32'h7FFF_FFFF);
      // R8 negative clamp
      directed("R8 exactly -2^31", 8'd249, 32'hCF00_0000, 32'h8000_0000);
      directed("R8 minus inf", 8'd248, 32'hFF80_0000, 32'h8000_0000);
      directed("R8 -2^40", 8'd248, 32'hD380_0000, 32'h8000_0000);

      // R2 pulse lasts one cycle and result holds
      directed("R2 load", 8'd249, 32'h4120_0000, 32'd10);
      @(negedge clk);
      check("R2 done low after pulse", {31'd0, done}, 32'd0);
      check("R2 result held", result, 32'd10);
      // R2 rejected codes
      for (int c = 246; c <= 251; c++) begin
         if (c == 248 || c == 249) continue;
         @(negedge clk);
         start = 1'b1;
         op_code = 8'(c);
         operand = 32'h42C8_0000;
         @(negedge clk);
         start = 1'b0;
         check("R2 bad code no done", {31'd0, done}, 32'd0);
         check("R2 bad code result kept", result, 32'd10);
      end

      // sweep all exponents, several fractions, both signs and codes
      for (int e = 0; e < 256; e++) begin
         for (int fi = 0; fi < 5; fi++) begin
            for (int s = 0; s < 2; s++) begin
               for (int m = 0; m < 2; m++) begin
                  run_case(m ? 8'd248 : 8'd249,
                           {s[0], e[7:0], frac_set[fi][22:0]});
               end
            end
         end
      end

      convert(8'd248, 32'h3FC0_0000, r);
      check("R4 1.5 round", r, 32'd2);

      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule